// File: doc/BRIEF.md
# Writable Microprogram Control Store

This block holds the microprogram of a microcoded control unit in read-write storage, so the microcode can be replaced without changing the silicon. An external agent, such as a console or a service processor, fills the store through a load port after power-on or reset. While it loads, the run-enable input stays low. The read path is then switched off, and the output register holds the all-zero NOP microword.

After the agent raises run-enable, the microsequencer presents a read address every cycle. The addressed microword is captured in a single pipeline register. The low-order bits of the microword form the next-address field, and they go back to the sequencer from that same register, so the loop through the store and the sequencer always contains a flop. A microword therefore takes effect one cycle after its address is presented.

Every word is stored with one parity bit that the loader supplies. The parity is checked on each enabled read, and a mismatch sets an error flag that stays set until reset.

Top module: `wcs_store`

## Requirements
- R1: A synchronous active-high reset clears the microword output, the next-address output and the parity error flag to zero on the next clock edge.
- R2: Reset does not alter the stored words: a word written before a reset is read back unchanged after it.
- R3: While run_en is low, every clock edge loads the all-zero NOP microword into the output, whatever rd_addr holds. No read can set the parity error flag in this state.
- R4: While run_en is high, the word stored at rd_addr appears on uinst_q after exactly one clock edge.
- R5: next_addr_q always equals the low log2(DEPTH) bits of the microword held in the output register, and it changes in the same cycle as that microword.
- R6: When a read and a write hit the same address at the same edge, the read returns the contents held before the write.
- R7: Each stored word keeps the ld_par bit written with it. Even parity means that ld_par equals the XOR of all data bits. If an enabled read finds a word whose stored bit differs from the XOR of its data bits, par_err is set at that edge.
- R8: par_err is sticky. Later reads of good words do not clear it; only reset does.
- R9: Writes are accepted whether run_en is high or low, and a word written at one edge is returned by a read at any later edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Microcycle clock |
| rst | input | 1 | Synchronous active-high reset |
| run_en | input | 1 | High once loading is finished; enables the read path |
| ld_we | input | 1 | Load port write strobe |
| ld_addr | input | log2(DEPTH) | Load port word address |
| ld_data | input | WORD_W | Microword to store |
| ld_par | input | 1 | Parity bit supplied by the loader (even parity over ld_data) |
| rd_addr | input | log2(DEPTH) | Read address from the microsequencer |
| uinst_q | output | WORD_W | Registered microinstruction |
| next_addr_q | output | log2(DEPTH) | Registered next-address field returned to the sequencer |
| par_err | output | 1 | Sticky parity error flag |

## Verification
The store is loaded with walking-one, walking-zero and mixed patterns. These show whether a stuck or swapped data bit or a wrong address decode leaks into the output. The words are read in ascending order and then in a strided descending order, which tells a true addressed read apart from a read that only follows the write order. A write that collides with a read of the same address shows whether old or new data is returned. A word written with wrong parity is read once with the read path disabled and once with it enabled, which checks that the parity check runs only on enabled reads. Reads of good words after the error, followed by a reset, show that the flag is sticky and that reset clears it.

// File: rtl/cs_pkg.sv
package cs_pkg;
  typedef enum logic {CS_LOAD = 1'b0, CS_RUN = 1'b1} cs_mode_e;

  localparam int PAR_MAX_W = 256;

  // Even parity bit of a word, zero-extended to PAR_MAX_W bits by the caller
  function automatic logic even_par(input logic [PAR_MAX_W-1:0] v);
    return ^v;
  endfunction
endpackage

// File: rtl/cs_array.sv
module cs_array #(
  parameter int DEPTH  = 64,
  parameter int WORD_W = 24,
  localparam int AW    = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              we,
  input  logic [AW-1:0]     waddr,
  input  logic [WORD_W-1:0] wdata,
  input  logic              wpar,
  input  logic [AW-1:0]     raddr,
  output logic [WORD_W-1:0] rdata,
  output logic              rpar
);
  logic [WORD_W:0] mem [DEPTH];

  // Write lands at the edge, the read is combinational, so a same-edge read sees old data
  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= {wpar, wdata};
  end

  assign {rpar, rdata} = mem[raddr];

  // R9
  wr_lands_chk: assert property (@(posedge clk) disable iff (rst)
    we |=> mem[$past(waddr)] == $past({wpar, wdata}));
endmodule

// File: rtl/cs_parity_chk.sv
module cs_parity_chk #(
  parameter int WORD_W = 24
) (
  input  logic [WORD_W-1:0] data,
  input  logic              par,
  output logic              mismatch
);
  logic calc;
  assign calc     = cs_pkg::even_par(cs_pkg::PAR_MAX_W'(data));
  assign mismatch = calc != par;
endmodule

// File: rtl/cs_pipe_reg.sv
module cs_pipe_reg #(
  parameter int WORD_W = 24,
  parameter int AW     = 6
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              fetch_en,
  input  logic [WORD_W-1:0] rd_word,
  input  logic              mismatch,
  output logic [WORD_W-1:0] uinst_q,
  output logic [AW-1:0]     nxt_q,
  output logic              err_q
);
  logic err_hit;
  assign err_hit = fetch_en && mismatch;

  always_ff @(posedge clk) begin
    if (rst) begin
      uinst_q <= '0;
      err_q   <= 1'b0;
    end else begin
      uinst_q <= fetch_en ? rd_word : '0;
      if (err_hit) err_q <= 1'b1;
    end
  end

  assign nxt_q = uinst_q[AW-1:0];

  // R1
  reset_clear_chk: assert property (@(posedge clk)
    rst |=> (uinst_q == '0) && !err_q);
  // R3
  nop_when_idle_chk: assert property (@(posedge clk) disable iff (rst)
    !fetch_en |=> uinst_q == '0);
  // R4
  fetch_lands_chk: assert property (@(posedge clk) disable iff (rst)
    fetch_en |=> uinst_q == $past(rd_word));
  // R8
  err_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    err_q |=> err_q);
  // R7
  err_cause_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(err_q) |-> $past(fetch_en && mismatch));
endmodule

// File: rtl/wcs_store.sv
module wcs_store #(
  parameter int DEPTH  = 64,
  parameter int WORD_W = 24,
  localparam int AW    = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              run_en,
  input  logic              ld_we,
  input  logic [AW-1:0]     ld_addr,
  input  logic [WORD_W-1:0] ld_data,
  input  logic              ld_par,
  input  logic [AW-1:0]     rd_addr,
  output logic [WORD_W-1:0] uinst_q,
  output logic [AW-1:0]     next_addr_q,
  output logic              par_err
);
  cs_pkg::cs_mode_e mode;
  logic              fetch_en;
  logic [WORD_W-1:0] rd_word;
  logic              rd_par;
  logic              mismatch;

  assign mode     = run_en ? cs_pkg::CS_RUN : cs_pkg::CS_LOAD;
  assign fetch_en = (mode == cs_pkg::CS_RUN);

  cs_array #(.DEPTH(DEPTH), .WORD_W(WORD_W)) u_array (
    .clk(clk), .rst(rst), .we(ld_we), .waddr(ld_addr), .wdata(ld_data),
    .wpar(ld_par), .raddr(rd_addr), .rdata(rd_word), .rpar(rd_par)
  );

  cs_parity_chk #(.WORD_W(WORD_W)) u_par (
    .data(rd_word), .par(rd_par), .mismatch(mismatch)
  );

  cs_pipe_reg #(.WORD_W(WORD_W), .AW(AW)) u_pipe (
    .clk(clk), .rst(rst), .fetch_en(fetch_en), .rd_word(rd_word),
    .mismatch(mismatch), .uinst_q(uinst_q), .nxt_q(next_addr_q), .err_q(par_err)
  );

  // R6
  collide_old_chk: assert property (@(posedge clk) disable iff (rst)
    (fetch_en && ld_we && ld_addr == rd_addr) |=> uinst_q == $past(rd_word));
endmodule

// File: tb/sim_wcs_store.sv
`timescale 1ns/1ps
module sim_wcs_store;
  localparam int DEPTH = 64;
  localparam int WW    = 24;
  localparam int AW    = 6;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic run_en = 1'b0;
  logic ld_we = 1'b0;
  logic [AW-1:0] ld_addr = '0;
  logic [WW-1:0] ld_data = '0;
  logic ld_par = 1'b0;
  logic [AW-1:0] rd_addr = '0;
  logic [WW-1:0] uinst_q;
  logic [AW-1:0] next_addr_q;
  logic par_err;

  int checks = 0;
  int errors = 0;
  logic [WW:0] ref_mem [DEPTH];
  logic [WW-1:0] exp_u = '0;
  logic exp_err = 1'b0;

  always #5 clk = ~clk;

  wcs_store #(.DEPTH(DEPTH), .WORD_W(WW)) u0 (
    .clk(clk), .rst(rst), .run_en(run_en), .ld_we(ld_we), .ld_addr(ld_addr),
    .ld_data(ld_data), .ld_par(ld_par), .rd_addr(rd_addr),
    .uinst_q(uinst_q), .next_addr_q(next_addr_q), .par_err(par_err)
  );

  function automatic logic [WW-1:0] pat(input int i);
    case (i % 4)
      0: return WW'(1) << (i % WW);
      1: return ~(WW'(1) << (i % WW));
      2: return WW'(i * 32'h00010101) ^ 24'hA5A5A5;
      default: return WW'(i) << 12 | WW'(63 - i);
    endcase
  endfunction

  task automatic step(input string req);
    @(posedge clk);
    if (rst) begin
      exp_u = '0;
      exp_err = 1'b0;
    end else if (run_en) begin
      exp_u = ref_mem[rd_addr][WW-1:0];
      if ((^ref_mem[rd_addr][WW-1:0]) != ref_mem[rd_addr][WW]) exp_err = 1'b1;
    end else begin
      exp_u = '0;
    end
    if (ld_we) ref_mem[ld_addr] = {ld_par, ld_data};
    @(negedge clk);
    checks++;
    if (uinst_q !== exp_u) begin
      errors++;
      $display("FAIL %s uinst_q actual %h expected %h", req, uinst_q, exp_u);
    end
    checks++;
    if (next_addr_q !== exp_u[AW-1:0]) begin
      errors++;
      $display("FAIL R5 next_addr_q actual %h expected %h", next_addr_q, exp_u[AW-1:0]);
    end
    checks++;
    if (par_err !== exp_err) begin
      errors++;
      $display("FAIL %s par_err actual %b expected %b", req, par_err, exp_err);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual timeout expected completion");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    for (int i = 0; i < DEPTH; i++) ref_mem[i] = '0;
    // reset state
    step("R1");
    step("R1");
    rst = 1'b0;
    // load phase: read path disabled, output holds NOP
    for (int i = 0; i < 16; i++) begin
      ld_we = 1'b1; ld_addr = AW'(i); ld_data = pat(i); ld_par = ^pat(i);
      rd_addr = AW'(15 - i);
      step("R3");
    end
    ld_we = 1'b0;
    // run: ascending reads
    run_en = 1'b1;
    for (int i = 0; i < 16; i++) begin
      rd_addr = AW'(i);
      step("R4");
    end
    // strided descending reads
    for (int i = 15; i >= 0; i -= 3) begin
      rd_addr = AW'(i);
      step("R5");
    end
    // reset keeps contents
    rst = 1'b1;
    step("R1");
    rst = 1'b0;
    for (int i = 0; i < 16; i++) begin
      rd_addr = AW'(i);
      step("R2");
    end
    // same-address write and read at one edge
    rd_addr = 6'd5; ld_we = 1'b1; ld_addr = 6'd5; ld_data = 24'hC3C3C3; ld_par = ^24'hC3C3C3;
    step("R6");
    ld_we = 1'b0;
    step("R9");
    // bad-parity word written while idle, read while idle
    run_en = 1'b0;
    ld_we = 1'b1; ld_addr = 6'd20; ld_data = 24'h000007; ld_par = 1'b0;
    rd_addr = 6'd20;
    step("R3");
    ld_we = 1'b0;
    step("R3");
    // enabled reads: good word, then the bad one
    run_en = 1'b1;
    rd_addr = 6'd3;
    step("R9");
    rd_addr = 6'd20;
    step("R7");
    rd_addr = 6'd4;
    step("R8");
    rd_addr = 6'd7;
    step("R8");
    rst = 1'b1;
    step("R8");
    rst = 1'b0;
    rd_addr = 6'd6;
    step("R1");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule